// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits beside a DRAM controller and governs two things: when the memory may first be used, and how often it must be refreshed. After reset it holds off for a fixed power-up pause. It then asks the controller for a run of initialization refresh cycles, and raises its ready flag only once the last of those has been acknowledged. From then on an interval timer produces one refresh demand per period, so that every row is refreshed inside the retention window. With 4096 rows and 64 ms retention, the period at 100 MHz is 1562 cycles.

The controller carries out each refresh as a CAS-before-RAS cycle, so the DRAM's own row counter supplies the address and no address leaves this block. Demands that the controller has not yet serviced accumulate in a backlog counter. The request line stays high while any demand is outstanding, so the controller can postpone refreshes and then catch up in a burst. If the backlog would grow beyond its limit, a sticky error flag is raised. The pause length, initialization count, interval and backlog limit are all parameters.

The interface is plain control signals, with no data stream. `refresh_req` is a level that the controller samples. Each cycle in which `refresh_ack` is high while `refresh_req` is high retires exactly one refresh.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `refresh_req`, `mem_ready` and `backlog_err` are all low.
- R2: `refresh_req` stays low for the first PAUSE_CYCLES-1 clock edges after reset is released. It is high after edge number PAUSE_CYCLES.
- R3: After the pause, `refresh_req` stays high until INIT_REFRESHES acknowledges have been received. An acknowledge given during the pause is not counted.
- R4: `mem_ready` rises on the clock edge that accepts the last initialization acknowledge. It then stays high until reset, whatever the backlog or error state.
- R5: Once ready, a refresh demand is added every INTERVAL_CYCLES edges. The first is added INTERVAL_CYCLES edges after the edge that accepted the final initialization acknowledge. `refresh_req` is high exactly while the backlog is non-zero.
- R6: Each edge on which `refresh_ack` is high while `refresh_req` is high retires one demand. An acknowledge while `refresh_req` is low has no effect.
- R7: A demand and an acknowledge accepted on the same edge leave the backlog unchanged.
- R8: The backlog never exceeds BACKLOG_MAX. A demand arriving while the backlog is full and no acknowledge is accepted is dropped and sets `backlog_err`. That flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_ack | input | 1 | Controller has issued one refresh cycle |
| refresh_req | output | 1 | Refresh outstanding (initialization or periodic) |
| mem_ready | output | 1 | Initialization finished; normal access allowed |
| backlog_err | output | 1 | Sticky: a refresh demand was lost to a full backlog |

## Verification
Every output is registered state, or is decoded straight from it. Each result is therefore visible in the half cycle after the edge that causes it. `refresh_req` rises right after edge PAUSE_CYCLES. `mem_ready` rises after the edge that accepts the last initialization acknowledge. Periodic demands appear after every INTERVAL_CYCLES edges counted from that same edge. Each scenario resets the block and counts edges from a known point. Acknowledges are driven on falling edges and outputs are sampled on falling edges, so every check falls on a computed edge count, one cycle before and at the edge where a change is due.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;
endpackage

// File: rtl/rfs_timer.sv
module rfs_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en)   cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);

  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  assert_idle_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/rfs_init_ctrl.sv
module rfs_init_ctrl
  import rfs_pkg::*;
#(
  parameter int INIT_REFRESHES = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pause_done,
  input  logic   ack,
  output phase_t phase,
  output logic   ready
);
  localparam int CW = $clog2(INIT_REFRESHES + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_REFRESHES - 1);

  logic [CW-1:0] done_cnt;
  logic          take;

  assign take = (phase == PH_INIT) && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_PAUSE;
      done_cnt <= '0;
      ready    <= 1'b0;
    end else begin
      case (phase)
        PH_PAUSE: if (pause_done) phase <= PH_INIT;
        PH_INIT: if (take) begin
          if (done_cnt == LAST) begin
            phase <= PH_RUN;
            ready <= 1'b1;
          end else begin
            done_cnt <= done_cnt + 1'b1;
          end
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assert_ready_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  assert_ready_only_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (phase == PH_RUN));
  assert_no_init_during_pause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE) |-> (done_cnt == '0));
endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog #(
  parameter int BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic demand,
  input  logic ack,
  output logic pending,
  output logic overflow
);
  localparam int BW = $clog2(BACKLOG_MAX + 1);
  localparam logic [BW-1:0] FULL = BW'(BACKLOG_MAX);

  logic [BW-1:0] depth;
  logic          retire;

  assign pending = (depth != '0);
  assign retire  = ack && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth    <= '0;
      overflow <= 1'b0;
    end else begin
      if (demand && !retire) begin
        if (depth == FULL) overflow <= 1'b1;
        else               depth    <= depth + 1'b1;
      end else if (retire && !demand) begin
        depth <= depth - 1'b1;
      end
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULL);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_idle_ack_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !demand) |=> !pending);
  assert_balanced_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (demand && retire) |=> $stable(depth));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import rfs_pkg::*;
#(
  parameter int PAUSE_CYCLES    = 20000,
  parameter int INIT_REFRESHES  = 8,
  parameter int INTERVAL_CYCLES = 1562,
  parameter int BACKLOG_MAX     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_ack,
  output logic refresh_req,
  output logic mem_ready,
  output logic backlog_err
);
  phase_t phase;
  logic   pause_done;
  logic   period_tick;
  logic   run_pending;

  rfs_timer #(.LIMIT(PAUSE_CYCLES)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_PAUSE), .tick(pause_done)
  );

  rfs_init_ctrl #(.INIT_REFRESHES(INIT_REFRESHES)) u_init (
    .clk(clk), .rst_n(rst_n), .pause_done(pause_done), .ack(refresh_ack),
    .phase(phase), .ready(mem_ready)
  );

  rfs_timer #(.LIMIT(INTERVAL_CYCLES)) u_period (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_RUN), .tick(period_tick)
  );

  rfs_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n), .demand(period_tick), .ack(refresh_ack),
    .pending(run_pending), .overflow(backlog_err)
  );

  assign refresh_req = (phase == PH_INIT) || run_pending;

  assert_no_req_in_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE) |-> !refresh_req);
  assert_req_until_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INIT) |-> (refresh_req && !mem_ready));
  assert_err_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    backlog_err |-> mem_ready);
endmodule

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
  localparam int PAUSE = 20;
  localparam int NINIT = 8;
  localparam int IVL   = 10;
  localparam int BMAX  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack = 1'b0;
  logic req, rdy, err;
  int   total = 0;
  int   bad = 0;
  int   cycles = 0;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYCLES(PAUSE), .INIT_REFRESHES(NINIT),
    .INTERVAL_CYCLES(IVL), .BACKLOG_MAX(BMAX)
  ) u_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .refresh_ack(ack),
    .refresh_req(req), .mem_ready(rdy), .backlog_err(err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ack(input int n);
    for (int i = 0; i < n; i++) begin
      ack = 1'b1;
      cyc(1);
      ack = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  // leaves the bench on the falling edge after the final init ack edge (t=0)
  task automatic bring_up();
    do_reset();
    cyc(PAUSE);
    pulse_ack(NINIT);
  endtask

  task automatic t_reset_and_pause();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(2);
    check("R1 req in reset", req, 1'b0);
    check("R1 ready in reset", rdy, 1'b0);
    check("R1 err in reset", err, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    check("R1 req after release", req, 1'b0);
    cyc(PAUSE - 2);
    check("R2 req before pause end", req, 1'b0);
    cyc(1);
    check("R2 req at pause end", req, 1'b1);
  endtask

  task automatic t_init_sequence();
    do_reset();
    ack = 1'b1;
    cyc(PAUSE - 1);
    ack = 1'b0;
    cyc(1);
    check("R3 req after pause with early acks", req, 1'b1);
    pulse_ack(NINIT - 1);
    check("R3 req one ack short", req, 1'b1);
    check("R4 ready one ack short", rdy, 1'b0);
    pulse_ack(1);
    check("R4 ready after last init ack", rdy, 1'b1);
    check("R5 req idle after init", req, 1'b0);
  endtask

  task automatic t_interval_and_backlog();
    bring_up();
    cyc(IVL - 1);
    check("R5 req before first period", req, 1'b0);
    cyc(1);
    check("R5 req at first period", req, 1'b1);
    cyc(2 * IVL);
    pulse_ack(2);
    check("R6 req with one of three left", req, 1'b1);
    pulse_ack(1);
    check("R6 req after backlog drained", req, 1'b0);
    check("R4 ready held", rdy, 1'b1);
  endtask

  task automatic t_idle_ack_and_overlap();
    bring_up();
    pulse_ack(1);
    cyc(1);
    check("R6 idle ack ignored", req, 1'b0);
    cyc(IVL - 2);
    check("R6 req after idle ack and one period", req, 1'b1);
    cyc(IVL - 1);
    pulse_ack(1);
    check("R7 req after ack on period edge", req, 1'b1);
    pulse_ack(1);
    check("R7 req after final ack", req, 1'b0);
  endtask

  task automatic t_overflow();
    bring_up();
    cyc(BMAX * IVL);
    check("R8 no err at full backlog", err, 1'b0);
    cyc(IVL);
    check("R8 err on lost demand", err, 1'b1);
    pulse_ack(BMAX - 1);
    check("R8 req with one left after saturation", req, 1'b1);
    pulse_ack(1);
    check("R8 req after saturated drain", req, 1'b0);
    check("R8 err sticky", err, 1'b1);
    check("R4 ready unaffected by error", rdy, 1'b1);
    do_reset();
    cyc(1);
    check("R1 err cleared by reset", err, 1'b0);
  endtask

  initial begin
    t_reset_and_pause();
    t_init_sequence();
    t_interval_and_backlog();
    t_idle_ack_and_overlap();
    t_overflow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule